// File: doc/BRIEF.md
# Display Controller Register Access Engine over SPI

This block is the host side of a serial link to a small LCD controller. It turns one request (a register write, a register read or a status read) into the byte frames the controller expects and returns the 16-bit result with a one-cycle done pulse. It drives the serial clock, the outgoing data line and an active-low chip select, and it samples the incoming data line. Pixel streaming is not handled here; this engine only carries configuration traffic.

Every frame opens with a command byte. That byte holds a fixed five-bit pattern, then a device-identity bit, then a bit that picks the index register or the data register, then a bit that picks write or read. Register accesses take two frames, with chip select released between them: the first loads the register index and the second moves the value. A status read takes a single frame of four bytes, and the byte that arrives right after the command byte is discarded. The serial clock is derived from the system clock by a divider sized at elaboration, so the register-access clock rate never exceeds the configured limit. A per-request option inverts every byte that is sent.

Top module: `lcd_reg_spi_master`

## Requirements
- R1: The command byte is {5'b01110, id, sel, dir}: bit 2 = id (the `dev_id` input latched at acceptance), bit 1 = sel (0 index register, 1 register data), bit 0 = dir (0 write, 1 read).
- R2: With `req_op` = 2'b00 (write), the engine sends frame one as [command sel=0 dir=0, 8'h00, index], then frame two as [command sel=1 dir=0, value[15:8], value[7:0]], and `rsp_data` is 16'h0000 at done.
- R3: With `req_op` = 2'b01 (read), frame one is the same as for a write and frame two is [command sel=1 dir=1, 8'h00, 8'h00]; `rsp_data` = {second byte received in frame two, third byte received in frame two}.
- R4: With `req_op[1]` = 1 (status), the engine sends one frame [command sel=0 dir=1, 8'h00, 8'h00, 8'h00]; `rsp_data` = {third received byte, fourth received byte}, and the second received byte is dropped.
- R5: `spi_cs_n` is low only while a frame is being sent, goes high between the two frames of a register access and after every frame, stays high while idle, and `spi_sclk` is high only while `spi_cs_n` is low.
- R6: When `tx_invert` is 1 at acceptance, every sent byte, padding bytes included, is the bitwise inverse of the R2 to R4 byte; received bytes are never inverted.
- R7: Bytes are shifted MSB first in mode 0: `spi_sclk` idles low, `spi_mosi` changes only while `spi_sclk` is low, and `spi_miso` is sampled at the rising edge of `spi_sclk`.
- R8: Each `spi_sclk` high phase lasts exactly HALF = ceil(CLK_HZ / (2*SCLK_MAX_HZ)) clock cycles and each low phase inside a frame lasts at least HALF cycles, so the serial clock never exceeds SCLK_MAX_HZ.
- R9: `req_ready` is high only when idle; it drops in the cycle after acceptance and stays low until done; `req_valid` while busy is ignored; `rsp_done` lasts exactly one cycle, and `req_ready` returns in the next cycle.
- R10: `rsp_done` is high in the cycle that starts T*HALF clock edges after the accepting edge, where T = 101 for register reads and writes and T = 66 for a status read.
- R11: After reset: `spi_cs_n` = 1, `spi_sclk` = 0, `spi_mosi` = 0, `req_ready` = 1, `rsp_done` = 0 and `rsp_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and accepting a request |
| req_op | input | 2 | 00 register write, 01 register read, 1x status read |
| req_index | input | 8 | Register index |
| req_wdata | input | 16 | Value for a register write |
| dev_id | input | 1 | Identity bit placed in every command byte |
| tx_invert | input | 1 | Invert every sent byte for this request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Read or status result, held until the next completion |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the controller |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from the controller |

## Verification
The divider steps every HALF clock cycles. A register access costs 101 such steps: two frames of one lead step, 48 bit steps and one trail step, plus one gap step. A status read costs 66 steps. The bench therefore counts clock edges from the accepting edge and expects `rsp_done` exactly T*HALF edges later. It samples all outputs on the falling clock edge, so each value it reads is the one a register produced at the previous rising edge. The cycle after done is checked for `rsp_done` low and `req_ready` high. Frame contents, serial-clock phase lengths and data-line stability are gathered cycle by cycle by a model of the controller and checked once each request completes.

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;

    localparam int WORD_W = 8;
    localparam int DATA_W = 2 * WORD_W;

    localparam logic SEL_INDEX = 1'b0;
    localparam logic SEL_DATA  = 1'b1;
    localparam logic DIR_WRITE = 1'b0;
    localparam logic DIR_READ  = 1'b1;

    typedef enum logic [1:0] {
        ACC_WR = 2'd0,
        ACC_RD = 2'd1,
        ACC_ST = 2'd2
    } acc_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_LEAD   = 3'd1,
        SQ_SHIFT  = 3'd2,
        SQ_TRAIL  = 3'd3,
        SQ_GAP    = 3'd4,
        SQ_FINISH = 3'd5
    } seq_state_e;

    function automatic acc_kind_e decode_op(logic [1:0] op);
        if (op[1])      return ACC_ST;
        else if (op[0]) return ACC_RD;
        else            return ACC_WR;
    endfunction

    function automatic logic [WORD_W-1:0] cmd_byte(logic id, logic sel, logic dir);
        return {5'b01110, id, sel, dir};
    endfunction

    // Plain (non-inverted) byte for a given access kind, frame and byte slot.
    function automatic logic [WORD_W-1:0] plain_byte(acc_kind_e k, logic fr, logic [1:0] slot,
                                                     logic id, logic [WORD_W-1:0] idx,
                                                     logic [DATA_W-1:0] wd);
        logic [WORD_W-1:0] v;
        v = '0;
        if (k == ACC_ST) begin
            v = (slot == 2'd0) ? cmd_byte(id, SEL_INDEX, DIR_READ) : '0;
        end else if (!fr) begin
            case (slot)
                2'd0:    v = cmd_byte(id, SEL_INDEX, DIR_WRITE);
                2'd1:    v = '0;
                default: v = idx;
            endcase
        end else if (k == ACC_WR) begin
            case (slot)
                2'd0:    v = cmd_byte(id, SEL_DATA, DIR_WRITE);
                2'd1:    v = wd[DATA_W-1:WORD_W];
                default: v = wd[WORD_W-1:0];
            endcase
        end else begin
            v = (slot == 2'd0) ? cmd_byte(id, SEL_DATA, DIR_READ) : '0;
        end
        return v;
    endfunction

endpackage

// File: rtl/lcd_sclk_tick.sv
module lcd_sclk_tick #(
    parameter int HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF + 1);
    localparam logic [CW-1:0] TOP = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en)             cnt_d = '0;
        else if (cnt_q == TOP) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = en && (cnt_q == TOP);

    generate
        if (HALF > 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);  // R8
        end
    endgenerate

endmodule

// File: rtl/lcd_spi_byte_shifter.sv
module lcd_spi_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_byte,
    input  logic         miso,
    output logic         sclk,
    output logic         mosi,
    output logic         byte_done,
    output logic [W-1:0] rx_byte
);
    localparam int PH_W = $clog2(2 * W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * W - 1);

    typedef struct packed {
        logic            active;
        logic            sclk;
        logic [PH_W-1:0] phase;
        logic [W-1:0]    tx;
        logic [W-1:0]    rx;
    } sh_state_t;

    sh_state_t d, q;

    always_comb begin
        d = q;
        byte_done = q.active && tick && q.sclk && (q.phase == PH_LAST);
        if (q.active && tick) begin
            if (!q.sclk) begin
                d.sclk  = 1'b1;
                d.rx    = {q.rx[W-2:0], miso};
                d.phase = q.phase + 1'b1;
            end else begin
                d.sclk = 1'b0;
                if (q.phase == PH_LAST) begin
                    d.active = 1'b0;
                end else begin
                    d.tx    = {q.tx[W-2:0], 1'b0};
                    d.phase = q.phase + 1'b1;
                end
            end
        end
        if (load) begin
            d.active = 1'b1;
            d.sclk   = 1'b0;
            d.phase  = '0;
            d.tx     = load_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk    = q.sclk;
    assign mosi    = q.active ? q.tx[W-1] : 1'b0;
    assign rx_byte = q.rx;

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));  // R7
    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!q.active || byte_done));  // R7

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcd_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [WORD_W-1:0] req_index,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              dev_id,
    input  logic              tx_invert,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic              cs_n,
    input  logic              tick,
    output logic              tick_en,
    output logic              sh_load,
    output logic [WORD_W-1:0] sh_byte,
    input  logic              byte_done,
    input  logic [WORD_W-1:0] rx_byte
);
    typedef struct packed {
        seq_state_e        st;
        acc_kind_e         kind;
        logic [WORD_W-1:0] idx;
        logic [DATA_W-1:0] wdata;
        logic              id;
        logic              inv;
        logic              frame;
        logic [1:0]        slot;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] data;
        logic              cs_n;
    } seq_t;

    seq_t d, q;

    logic [1:0]        last_slot;
    logic              last_frame;
    logic [WORD_W-1:0] cur_byte, nxt_byte;

    always_comb begin
        last_slot  = (q.kind == ACC_ST) ? 2'd3 : 2'd2;
        last_frame = (q.kind == ACC_ST) || q.frame;
        cur_byte   = plain_byte(q.kind, q.frame, q.slot, q.id, q.idx, q.wdata)
                     ^ {WORD_W{q.inv}};
        nxt_byte   = plain_byte(q.kind, q.frame, q.slot + 2'd1, q.id, q.idx, q.wdata)
                     ^ {WORD_W{q.inv}};

        d       = q;
        sh_load = 1'b0;
        sh_byte = '0;

        case (q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    d.st    = SQ_LEAD;
                    d.kind  = decode_op(req_op);
                    d.idx   = req_index;
                    d.wdata = req_wdata;
                    d.id    = dev_id;
                    d.inv   = tx_invert;
                    d.frame = 1'b0;
                    d.slot  = 2'd0;
                    d.acc   = '0;
                    d.cs_n  = 1'b0;
                end
            end
            SQ_LEAD: begin
                if (tick) begin
                    sh_load = 1'b1;
                    sh_byte = cur_byte;
                    d.st    = SQ_SHIFT;
                end
            end
            SQ_SHIFT: begin
                if (byte_done) begin
                    d.acc = {q.acc[WORD_W-1:0], rx_byte};
                    if (q.slot == last_slot) begin
                        d.st = SQ_TRAIL;
                    end else begin
                        d.slot  = q.slot + 2'd1;
                        sh_load = 1'b1;
                        sh_byte = nxt_byte;
                    end
                end
            end
            SQ_TRAIL: begin
                if (tick) begin
                    d.cs_n = 1'b1;
                    if (last_frame) begin
                        d.st   = SQ_FINISH;
                        d.data = (q.kind == ACC_WR) ? '0 : q.acc;
                    end else begin
                        d.st    = SQ_GAP;
                        d.frame = 1'b1;
                    end
                end
            end
            SQ_GAP: begin
                if (tick) begin
                    d.st   = SQ_LEAD;
                    d.slot = 2'd0;
                    d.cs_n = 1'b0;
                end
            end
            SQ_FINISH: d.st = SQ_IDLE;
            default:   d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= SQ_IDLE;
            q.kind <= ACC_WR;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == SQ_IDLE);
    assign rsp_done  = (q.st == SQ_FINISH);
    assign rsp_data  = q.data;
    assign cs_n      = q.cs_n;
    assign tick_en   = (q.st != SQ_IDLE) && (q.st != SQ_FINISH);

    AST_BYTE_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !q.cs_n);  // R5
    AST_REQ_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !rsp_done) |=> $stable(q.kind));  // R9

endmodule

// File: rtl/lcd_reg_spi_master.sv
module lcd_reg_spi_master
    import lcd_reg_pkg::*;
#(
    parameter int CLK_HZ      = 24_000_000,
    parameter int SCLK_MAX_HZ = 4_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_op,
    input  logic [7:0]  req_index,
    input  logic [15:0] req_wdata,
    input  logic        dev_id,
    input  logic        tx_invert,
    output logic        rsp_done,
    output logic [15:0] rsp_data,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n,
    input  logic        spi_miso
);
    localparam int HALF_RAW = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
    localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

    logic              tick, tick_en;
    logic              sh_load, byte_done;
    logic [WORD_W-1:0] sh_byte, rx_byte;

    lcd_sclk_tick #(.HALF(HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .tick  (tick)
    );

    lcd_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_index (req_index),
        .req_wdata (req_wdata),
        .dev_id    (dev_id),
        .tx_invert (tx_invert),
        .rsp_done  (rsp_done),
        .rsp_data  (rsp_data),
        .cs_n      (spi_cs_n),
        .tick      (tick),
        .tick_en   (tick_en),
        .sh_load   (sh_load),
        .sh_byte   (sh_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    lcd_spi_byte_shifter #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (sh_load),
        .load_byte (sh_byte),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n);  // R5
    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);  // R5
    AST_CS_RISE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> !spi_sclk);  // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);  // R9
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> req_ready);  // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);  // R9

endmodule

// File: tb/tb_lcd_reg_spi_master.sv
module tb_lcd_reg_spi_master;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 24_000_000;
    localparam int SCLK_HZ    = 4_000_000;
    localparam int HALF       = (CLK_HZ + 2 * SCLK_HZ - 1) / (2 * SCLK_HZ);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [7:0]  req_index = 8'h00;
    logic [15:0] req_wdata = 16'h0000;
    logic        dev_id = 1'b0;
    logic        tx_invert = 1'b0;
    logic        req_ready, rsp_done, spi_sclk, spi_mosi, spi_cs_n, spi_miso;
    logic [15:0] rsp_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_reg_spi_master #(.CLK_HZ(CLK_HZ), .SCLK_MAX_HZ(SCLK_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_index(req_index), .req_wdata(req_wdata),
        .dev_id(dev_id), .tx_invert(tx_invert), .rsp_done(rsp_done),
        .rsp_data(rsp_data), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
    );

    // ---------------- controller model ----------------
    int         frame_total = 0;
    logic [7:0] cap [0:3][0:3];
    int         cap_n [0:3];
    int         bitc = 0;
    logic [7:0] rxsr = 8'h00;
    logic [7:0] txsr = 8'h00;

    function automatic logic [7:0] resp_byte(int f, int b);
        return 8'((f * 37 + b * 91 + 5) % 256);
    endfunction

    assign spi_miso = txsr[7];

    always @(negedge spi_cs_n) begin
        cap_n[frame_total % 4] = 0;
        bitc = 0;
        txsr = resp_byte(frame_total, 0);
    end

    always @(posedge spi_cs_n) begin
        if (rst_n) frame_total = frame_total + 1;
    end

    always @(posedge spi_sclk) begin
        rxsr = {rxsr[6:0], spi_mosi};
        bitc = bitc + 1;
        if (bitc == 8) begin
            cap[frame_total % 4][cap_n[frame_total % 4] % 4] = rxsr;
            cap_n[frame_total % 4] = cap_n[frame_total % 4] + 1;
            bitc = 0;
        end
    end

    always @(negedge spi_sclk) begin
        if (bitc == 0) txsr = resp_byte(frame_total, cap_n[frame_total % 4]);
        else           txsr = {txsr[6:0], 1'b0};
    end

    // ---------------- cycle monitor ----------------
    int   hi_run = 0, lo_run = 0;
    int   bad_run = 0, bad_mosi = 0, bad_cs = 0, bad_done = 0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_sclk) begin
                if (!prev_sclk) begin
                    if (lo_run < HALF) bad_run = bad_run + 1;
                    lo_run = 0;
                    hi_run = 0;
                end
                hi_run = hi_run + 1;
                if (spi_cs_n) bad_cs = bad_cs + 1;
                if (prev_sclk && (spi_mosi !== prev_mosi)) bad_mosi = bad_mosi + 1;
            end else begin
                if (prev_sclk) begin
                    if (hi_run != HALF) bad_run = bad_run + 1;
                    hi_run = 0;
                    lo_run = 0;
                end
                lo_run = lo_run + 1;
            end
            if (rsp_done && prev_done) bad_done = bad_done + 1;
        end
        prev_sclk = spi_sclk;
        prev_mosi = spi_mosi;
        prev_done = rsp_done;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cmd(bit id, bit sel, bit dir);
        return 8'h70 | (8'(id) << 2) | (8'(sel) << 1) | 8'(dir);
    endfunction

    task automatic run_txn(logic [1:0] op, logic [7:0] idx, logic [15:0] wd,
                           bit id, bit inv, bit poke);
        int         fbase, nf, n, rdy_bad, t_steps;
        int         s_run, s_mosi, s_cs, s_done;
        logic [7:0] exp_b [0:1][0:3];
        int         exp_n [0:1];
        logic [15:0] exp_data;
        logic [7:0] m;
        bit         is_st;
        string      tag;

        is_st = op[1];
        m = inv ? 8'hFF : 8'h00;
        fbase = frame_total;
        s_run = bad_run; s_mosi = bad_mosi; s_cs = bad_cs; s_done = bad_done;

        if (is_st) begin
            nf = 1; t_steps = 66; exp_n[0] = 4; exp_n[1] = 0;
            exp_b[0][0] = cmd(id, 0, 1) ^ m;
            exp_b[0][1] = m; exp_b[0][2] = m; exp_b[0][3] = m;
            exp_data = {resp_byte(fbase, 2), resp_byte(fbase, 3)};
            tag = "R4";
        end else begin
            nf = 2; t_steps = 101; exp_n[0] = 3; exp_n[1] = 3;
            exp_b[0][0] = cmd(id, 0, 0) ^ m; exp_b[0][1] = m; exp_b[0][2] = idx ^ m;
            exp_b[0][3] = 8'h00; exp_b[1][3] = 8'h00;
            if (op[0]) begin
                exp_b[1][0] = cmd(id, 1, 1) ^ m; exp_b[1][1] = m; exp_b[1][2] = m;
                exp_data = {resp_byte(fbase + 1, 1), resp_byte(fbase + 1, 2)};
                tag = "R3";
            end else begin
                exp_b[1][0] = cmd(id, 1, 0) ^ m;
                exp_b[1][1] = wd[15:8] ^ m; exp_b[1][2] = wd[7:0] ^ m;
                exp_data = 16'h0000;
                tag = "R2";
            end
        end

        @(negedge clk);
        req_op = op; req_index = idx; req_wdata = wd;
        dev_id = id; tx_invert = inv; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; rdy_bad = 0;
        while (!rsp_done && n < 4000) begin
            if (req_ready) rdy_bad = rdy_bad + 1;
            if (poke && n == 40) begin req_valid = 1'b1; req_op = 2'b10; end
            if (poke && n == 41) req_valid = 1'b0;
            n = n + 1;
            @(negedge clk);
        end

        chk(n == t_steps * HALF, "R10 done latency", n, t_steps * HALF);
        chk(rdy_bad == 0, "R9 ready low while busy", rdy_bad, 0);
        chk(rsp_data == exp_data, {tag, " result data"}, rsp_data, exp_data);
        chk(spi_cs_n == 1'b1, "R5 cs high at done", spi_cs_n, 1);
        chk(frame_total - fbase == nf, "R5 frame count", frame_total - fbase, nf);
        for (int f = 0; f < nf; f++) begin
            chk(cap_n[(fbase + f) % 4] == exp_n[f], {tag, " bytes per frame"},
                cap_n[(fbase + f) % 4], exp_n[f]);
            for (int b = 0; b < exp_n[f]; b++) begin
                if (b == 0)
                    chk(cap[(fbase + f) % 4][b] == exp_b[f][b],
                        inv ? "R1 R6 command byte" : "R1 command byte",
                        cap[(fbase + f) % 4][b], exp_b[f][b]);
                else
                    chk(cap[(fbase + f) % 4][b] == exp_b[f][b],
                        inv ? {tag, " R6 payload byte"} : {tag, " payload byte"},
                        cap[(fbase + f) % 4][b], exp_b[f][b]);
            end
        end

        @(negedge clk);
        chk(rsp_done == 1'b0, "R9 done one cycle", rsp_done, 0);
        chk(req_ready == 1'b1, "R9 ready after done", req_ready, 1);

        if (poke) begin
            repeat (10) @(negedge clk);
            chk(spi_cs_n == 1'b1 && frame_total - fbase == nf,
                "R9 request while busy ignored", frame_total - fbase, nf);
        end

        chk(bad_run == s_run, "R8 sclk phase length", bad_run - s_run, 0);
        chk(bad_mosi == s_mosi, "R7 mosi stable while sclk high", bad_mosi - s_mosi, 0);
        chk(bad_cs == s_cs, "R5 sclk only inside frame", bad_cs - s_cs, 0);
        chk(bad_done == s_done, "R9 done width", bad_done - s_done, 0);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] idx_set [0:3];
        idx_set[0] = 8'h00; idx_set[1] = 8'h5A; idx_set[2] = 8'hA5; idx_set[3] = 8'hFF;

        repeat (4) @(negedge clk);
        // R11: reset values
        chk(spi_cs_n == 1'b1, "R11 cs_n reset", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R11 sclk reset", spi_sclk, 0);
        chk(spi_mosi == 1'b0, "R11 mosi reset", spi_mosi, 0);
        chk(req_ready == 1'b1, "R11 ready reset", req_ready, 1);
        chk(rsp_done == 1'b0, "R11 done reset", rsp_done, 0);
        chk(rsp_data == 16'h0000, "R11 data reset", rsp_data, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1 && req_ready == 1'b1, "R11 idle after reset", {spi_cs_n, req_ready}, 2'b11);

        // R8: divider keeps the serial clock within its limit
        chk(CLK_HZ / (2 * HALF) <= SCLK_HZ, "R8 sclk rate", CLK_HZ / (2 * HALF), SCLK_HZ);

        for (int id = 0; id < 2; id++)
            for (int inv = 0; inv < 2; inv++)
                for (int op = 0; op < 4; op++)
                    for (int k = 0; k < 4; k++)
                        run_txn(2'(op), idx_set[k],
                                {idx_set[k] ^ 8'h3C, ~idx_set[k] ^ 8'(op * 17 + k)},
                                id[0], inv[0], (k == 1));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule